// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for Byte Data

This block guards an 8-bit data byte with a 13-bit codeword. On the write side it spreads the byte across twelve numbered bit positions. Check bits go at the positions that are powers of two. An overall even-parity bit is appended. On the read side it takes a 13-bit word and recomputes a 4-bit syndrome. It repairs any single flipped data bit and reports the kind of fault it found.

The two paths are independent. Each has a request strobe. Its result is registered and appears one clock after the request, together with a done pulse. The result then holds until the next request on that path. Typical use is between a storage array and its client: the encode result is written into the array, and each word read from the array goes through the decode path.

Top module: `secded8_codec`

## Requirements
- R1: Codeword index i-1 holds position i for positions 1 to 12. Data bits d0..d7 sit in positions 3, 5, 6, 7, 9, 10, 11, 12, in that order. Let S be the XOR of the position numbers of all data bits that are 1; position 2^j holds bit j of S, for j = 0..3. Index 12 makes the count of ones over all 13 bits even.
- R2: When encReq is high at a clock edge, encWord carries the codeword and encDone is high after that edge. When encReq is low, encDone is low and encWord keeps its value.
- R3: A word with no flipped bit decodes to its data field, with singleErr, doubleErr and checkErr all low.
- R4: A single flip at a data position is corrected. decData equals the original byte, singleErr=1 and checkErr=0.
- R5: A single flip at position 1, 2, 4 or 8 gives a syndrome with exactly one bit set. decData equals the data field unchanged, singleErr=1 and checkErr=1.
- R6: A flip of only the overall parity bit (index 12) gives a zero syndrome with odd parity. decData is unchanged, singleErr=1 and checkErr=1.
- R7: Any two flipped bits give doubleErr=1, singleErr=0 and checkErr=0. decData equals the received data field with no correction applied.
- R8: Odd overall parity with a syndrome of 13, 14 or 15 points at no real position. It is reported as doubleErr=1, with singleErr=0 and the data field uncorrected.
- R9: When decReq is high at a clock edge, the decode results and decDone appear after that edge. When decReq is low, decDone is low and all decode outputs hold.
- R10: After reset, every output is zero. singleErr and doubleErr are never high together.
- R11: Byte 0x39 encodes to 0x134F, with check value 0111. Flipping position 6 of that word gives syndrome 0110, and the byte 0x39 is restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| encReq | input | 1 | Encode request |
| encData | input | 8 | Byte to encode |
| decReq | input | 1 | Decode request |
| decWord | input | 13 | Received codeword |
| encDone | output | 1 | Encode result valid pulse |
| encWord | output | 13 | Encoded codeword |
| decDone | output | 1 | Decode result valid pulse |
| decData | output | 8 | Corrected byte |
| singleErr | output | 1 | One bit was in error |
| doubleErr | output | 1 | Uncorrectable error |
| checkErr | output | 1 | The single error lay in a check or parity bit |

## Verification
The hardest case to reach is R8: odd parity paired with a syndrome that names no existing position. No one- or two-bit fault produces it. The bench therefore flips every three-bit combination of positions on two codewords. It computes the syndrome of each flip set arithmetically and checks only the sets that land on 13 to 15. Flip positions such as 1, 4 and 8 reach those values. Every byte is also swept through all 13 single flips and all 78 double flips.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;

  // Smallest count of check bits covering dataW data bits plus themselves.
  function automatic int chkBits(input int dataW);
    int r;
    r = 0;
    for (int t = 1; t < 16; t++) begin
      if (r == 0 && (1 << t) >= dataW + t + 1) r = t;
    end
    return r;
  endfunction

  // Position number (from 1) of the k-th data bit: the k-th non-power-of-two.
  function automatic int dataPos(input int k);
    int p;
    int seen;
    p = 0;
    seen = -1;
    for (int q = 1; q < 256; q++) begin
      if (p == 0 && (q & (q - 1)) != 0) begin
        seen = seen + 1;
        if (seen == k) p = q;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int POS_N = DATA_W + CHK_W,
  localparam int CW_W  = POS_N + 1
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CW_W-1:0]   codeWord
);

  logic [POS_N-1:0] body;
  logic [CHK_W-1:0] posXor;

  always_comb begin
    posXor = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (dataIn[k]) posXor = posXor ^ CHK_W'(dataPos(k));
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_data
    localparam int P = dataPos(k);
    assign body[P-1] = dataIn[k];
  end

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    assign body[(1 << j) - 1] = posXor[j];
  end

  assign codeWord = {^body, body};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int POS_N = DATA_W + CHK_W,
  localparam int CW_W  = POS_N + 1
) (
  input  logic [CW_W-1:0]   word,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] rawData,
  output logic              singleErr,
  output logic              doubleErr,
  output logic              checkErr
);

  logic [CHK_W-1:0] term [POS_N];
  logic [CHK_W-1:0] syn;
  logic             parOdd;
  logic [POS_N-1:0] fixMask;
  logic [POS_N-1:0] fixed;

  for (genvar p = 1; p <= POS_N; p++) begin : g_term
    assign term[p-1] = word[p-1] ? CHK_W'(p) : '0;
  end

  always_comb begin
    syn = '0;
    for (int p = 0; p < POS_N; p++) syn = syn ^ term[p];
  end

  assign parOdd = ^word;

  always_comb begin
    singleErr = 1'b0;
    doubleErr = 1'b0;
    checkErr  = 1'b0;
    fixMask   = '0;
    if (syn == '0) begin
      singleErr = parOdd;
      checkErr  = parOdd;
    end else if (!parOdd) begin
      doubleErr = 1'b1;
    end else if (int'(syn) > POS_N) begin
      doubleErr = 1'b1;
    end else if ($onehot(syn)) begin
      singleErr = 1'b1;
      checkErr  = 1'b1;
    end else begin
      singleErr = 1'b1;
      fixMask   = POS_N'(1) << (syn - CHK_W'(1));
    end
  end

  assign fixed = word[POS_N-1:0] ^ fixMask;

  for (genvar k = 0; k < DATA_W; k++) begin : g_out
    localparam int P = dataPos(k);
    assign dataOut[k] = fixed[P-1];
    assign rawData[k] = word[P-1];
  end

endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    encReq,
  input  logic    decReq,
  output strobe_t stb,
  output logic    encDone,
  output logic    decDone
);

  assign stb.encLoad = encReq;
  assign stb.decLoad = decReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encDone <= 1'b0;
      decDone <= 1'b0;
    end else begin
      encDone <= encReq;
      decDone <= decReq;
    end
  end

  AST_ENC_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    encReq |=> encDone) else $error("encDone missing"); // R2
  AST_ENC_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !encReq |=> !encDone) else $error("spurious encDone"); // R2
  AST_DEC_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    decReq |=> decDone) else $error("decDone missing"); // R9

endmodule

// File: rtl/secded_dpath.sv
module secded_dpath
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int CW_W  = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] encData,
  input  logic [CW_W-1:0]   decWord,
  output logic [CW_W-1:0]   encWord,
  output logic [DATA_W-1:0] decData,
  output logic              singleErr,
  output logic              doubleErr,
  output logic              checkErr
);

  logic [CW_W-1:0]   encNext;
  logic [DATA_W-1:0] decNext;
  logic [DATA_W-1:0] rawNext;
  logic              sglNext;
  logic              dblNext;
  logic              chkNext;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .dataIn   (encData),
    .codeWord (encNext)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .word      (decWord),
    .dataOut   (decNext),
    .rawData   (rawNext),
    .singleErr (sglNext),
    .doubleErr (dblNext),
    .checkErr  (chkNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encWord <= '0;
    end else if (stb.encLoad) begin
      encWord <= encNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decData   <= '0;
      singleErr <= 1'b0;
      doubleErr <= 1'b0;
      checkErr  <= 1'b0;
    end else if (stb.decLoad) begin
      decData   <= decNext;
      singleErr <= sglNext;
      doubleErr <= dblNext;
      checkErr  <= chkNext;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(singleErr && doubleErr)) else $error("both flags set"); // R10
  AST_CHECK_NEEDS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    checkErr |-> singleErr) else $error("checkErr without singleErr"); // R5
  AST_AT_MOST_ONE_FIX: assert property (@(posedge clk) disable iff (!rstN)
    stb.decLoad |-> $countones(decNext ^ rawNext) <= 1) else $error("multi-bit fix"); // R4
  AST_DOUBLE_NO_FIX: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decLoad && dblNext) |-> decNext == rawNext) else $error("fix on double"); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.decLoad |=> $stable(decData) && $stable(singleErr)) else $error("decode drift"); // R9
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.encLoad |=> $stable(encWord)) else $error("encode drift"); // R2
  AST_ENC_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    stb.encLoad |=> (^encWord) == 1'b0) else $error("odd codeword"); // R1

endmodule

// File: rtl/secded8_codec.sv
module secded8_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW_W  = DATA_W + chkBits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encReq,
  input  logic [DATA_W-1:0] encData,
  input  logic              decReq,
  input  logic [CW_W-1:0]   decWord,
  output logic              encDone,
  output logic [CW_W-1:0]   encWord,
  output logic              decDone,
  output logic [DATA_W-1:0] decData,
  output logic              singleErr,
  output logic              doubleErr,
  output logic              checkErr
);

  strobe_t stb;

  secded_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .encReq  (encReq),
    .decReq  (decReq),
    .stb     (stb),
    .encDone (encDone),
    .decDone (decDone)
  );

  secded_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .encData   (encData),
    .decWord   (decWord),
    .encWord   (encWord),
    .decData   (decData),
    .singleErr (singleErr),
    .doubleErr (doubleErr),
    .checkErr  (checkErr)
  );

endmodule

// File: tb/secded8_codec_tb.sv
module secded8_codec_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encReq = 1'b0;
  logic [7:0]  encData = '0;
  logic        decReq = 1'b0;
  logic [12:0] decWord = '0;
  logic        encDone;
  logic [12:0] encWord;
  logic        decDone;
  logic [7:0]  decData;
  logic        singleErr;
  logic        doubleErr;
  logic        checkErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  secded8_codec u_dut (
    .clk(clk), .rstN(rstN), .encReq(encReq), .encData(encData),
    .decReq(decReq), .decWord(decWord), .encDone(encDone), .encWord(encWord),
    .decDone(decDone), .decData(decData), .singleErr(singleErr),
    .doubleErr(doubleErr), .checkErr(checkErr)
  );

  function automatic int posOf(input int k);
    case (k)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  function automatic logic [12:0] model(input logic [7:0] d);
    logic [3:0]  x;
    logic [12:0] w;
    x = '0;
    w = '0;
    for (int k = 0; k < 8; k++) begin
      if (d[k]) begin
        w[posOf(k)-1] = 1'b1;
        x = x ^ 4'(posOf(k));
      end
    end
    w[0] = x[0]; w[1] = x[1]; w[3] = x[2]; w[7] = x[3];
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] fieldOf(input logic [12:0] w);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) d[k] = w[posOf(k)-1];
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // result packed as {data, single, double, check}
  function automatic logic [10:0] got();
    return {decData, singleErr, doubleErr, checkErr};
  endfunction

  task automatic doEnc(input logic [7:0] d);
    @(negedge clk);
    encReq = 1'b1; encData = d;
    @(negedge clk);
    encReq = 1'b0;
  endtask

  task automatic doDec(input logic [12:0] w);
    @(negedge clk);
    decReq = 1'b1; decWord = w;
    @(negedge clk);
    decReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] cw;
    logic [12:0] hold;
    repeat (3) @(negedge clk);
    // R10: reset state
    check({encDone, encWord, decDone, decData, singleErr, doubleErr, checkErr} == '0,
          "R10 reset", {encWord, decData}, 0);
    rstN = 1'b1;

    // R11: worked example
    doEnc(8'h39);
    check(encWord == 13'h134F && encDone, "R11 encode", encWord, 13'h134F);
    // R2: hold with no request, input changing
    hold = encWord;
    encData = 8'hFF;
    @(negedge clk);
    check(encWord == hold && !encDone, "R2 hold", {encDone, encWord}, hold);
    doDec(13'h134F ^ 13'h0020);
    check(got() == {8'h39, 3'b100} && decDone, "R11 fix pos6", got(), {8'h39, 3'b100});
    // R9: hold with no request
    hold = {2'b0, got()};
    decWord = 13'h1FFF;
    @(negedge clk);
    check({2'b0, got()} == hold && !decDone, "R9 hold", {decDone, got()}, hold);

    for (int d = 0; d < 256; d++) begin
      cw = model(8'(d));
      doEnc(8'(d));
      check(encWord == cw && encDone, "R1 R2 encode", encWord, cw);
      doDec(cw);
      check(got() == {8'(d), 3'b000} && decDone, "R3 clean", got(), {8'(d), 3'b000});
      for (int p = 1; p <= 13; p++) begin
        bit isChk;
        isChk = (p == 1 || p == 2 || p == 4 || p == 8 || p == 13);
        doDec(cw ^ (13'd1 << (p - 1)));
        if (p == 13)
          check(got() == {8'(d), 3'b101}, "R6 parity flip", got(), {8'(d), 3'b101});
        else if (isChk)
          check(got() == {8'(d), 3'b101}, "R5 check flip", got(), {8'(d), 3'b101});
        else
          check(got() == {8'(d), 3'b100}, "R4 data flip", got(), {8'(d), 3'b100});
      end
      for (int a = 1; a <= 13; a++) begin
        for (int b = a + 1; b <= 13; b++) begin
          logic [12:0] bad;
          bad = cw ^ (13'd1 << (a - 1)) ^ (13'd1 << (b - 1));
          doDec(bad);
          check(got() == {fieldOf(bad), 3'b010}, "R7 double", got(), {fieldOf(bad), 3'b010});
        end
      end
    end

    // R8: triple flips whose syndrome lands on 13..15
    for (int v = 0; v < 2; v++) begin
      cw = model(v == 0 ? 8'h39 : 8'hC6);
      for (int a = 1; a <= 13; a++)
        for (int b = a + 1; b <= 13; b++)
          for (int c = b + 1; c <= 13; c++) begin
            logic [3:0]  s;
            logic [12:0] bad;
            s = 4'((a < 13) ? a : 0) ^ 4'((b < 13) ? b : 0) ^ 4'((c < 13) ? c : 0);
            if (s >= 4'd13) begin
              bad = cw ^ (13'd1 << (a - 1)) ^ (13'd1 << (b - 1)) ^ (13'd1 << (c - 1));
              doDec(bad);
              check(got() == {fieldOf(bad), 3'b010}, "R8 phantom syndrome",
                    got(), {fieldOf(bad), 3'b010});
            end
          end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule